// File: doc/BRIEF.md
# Drink Dispenser Credit Controller

This block is the control state machine of a two-product drink dispenser. It accepts single-cycle strobes for 5¢, 10¢ and 25¢ coins and for the regular and diet selection buttons. These inputs are assumed to be already debounced and edge-detected. The credit held so far is carried only in the state encoding. No adder or subtractor appears anywhere in the logic. Both products cost 45¢.

Once the price has been reached, the machine refuses further coins. It waits for a selection, releases the matching drink with a one-clock pulse, and then pays back the surplus as a run of one-clock pulses, one for each 5¢. A status flag tells the coin path whether coins are currently being taken.

Top module: `vend_ctrl`

## Requirements
- R1: While credit is below 45¢, a `nickel`, `dime` or `quarter` strobe raises the credit by 5¢, 10¢ or 25¢. `status` is high exactly while the machine sits at a credit of 0¢ to 40¢ with no payback in progress.
- R2: When several coin strobes arrive in the same cycle, only the highest-value coin is credited.
- R3: With credit at or above 45¢, a selection strobe produces one single-cycle pulse, in the clock cycle after the strobe. The pulse is on `give_soda` for `soda` and on `give_diet` for `diet`. If both strobes come together, `soda` wins.
- R4: After a sale at credit C, `change` pulses (C-45)/5 times in consecutive cycles, starting the cycle after the give pulse. `change` never coincides with a give pulse.
- R5: With credit at or above 45¢, coin strobes have no effect: `status` stays low and the later payback reflects only the credit held when the price was reached.
- R6: Selection strobes while credit is below 45¢ produce no give pulse and leave the credit unchanged.
- R7: Coin and selection strobes arriving during the give or payback cycles are ignored.
- R8: Synchronous active-high `rst` returns the machine to 0¢, with all pulse outputs low and `status` high in the cycle after the reset edge.
- R9: When the payback is finished, or right after a 45¢ sale, the machine is back at 0¢ and accepting coins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nickel | input | 1 | 5¢ coin strobe |
| dime | input | 1 | 10¢ coin strobe |
| quarter | input | 1 | 25¢ coin strobe |
| soda | input | 1 | Regular drink select strobe |
| diet | input | 1 | Diet drink select strobe |
| give_soda | output | 1 | One-cycle release pulse, regular drink |
| give_diet | output | 1 | One-cycle release pulse, diet drink |
| change | output | 1 | One-cycle pulse per 5¢ returned |
| status | output | 1 | High while coins are accepted |

## Verification
Two kinds of event can land in the same cycle.

The first is a coin strobe together with a selection strobe. This is driven both at low credit, where the coin must count and the selection must be dropped, and at paid credit, where the coin must be dropped and the selection must sell.

The second is fresh strobes during the give and payback cycles. These are driven while a 65¢ purchase unwinds, and random traffic also produces them.

In every case a bench model of cents and pending nickels predicts all four outputs for each cycle, and the outputs are compared against it.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Credit states (ST_Cxx accepting, ST_Pxx paid) and payback states (ST_Kn: n nickels owed)
  typedef enum logic [4:0] {
    ST_C00, ST_C05, ST_C10, ST_C15, ST_C20, ST_C25, ST_C30, ST_C35, ST_C40,
    ST_P45, ST_P50, ST_P55, ST_P60, ST_P65,
    ST_K4,  ST_K3,  ST_K2,  ST_K1
  } vst_t;

  typedef enum logic [1:0] {COIN_NONE, COIN_5, COIN_10, COIN_25} coin_t;
  typedef enum logic [1:0] {PICK_NONE, PICK_REG, PICK_DIET} pick_t;

  function automatic logic is_accepting(input vst_t s);
    case (s)
      ST_C00, ST_C05, ST_C10, ST_C15, ST_C20,
      ST_C25, ST_C30, ST_C35, ST_C40: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic is_paid(input vst_t s);
    case (s)
      ST_P45, ST_P50, ST_P55, ST_P60, ST_P65: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  function automatic logic is_payback(input vst_t s);
    case (s)
      ST_K4, ST_K3, ST_K2, ST_K1: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  // Choose among three successor states by coin value; hold on no coin
  function automatic vst_t by_coin(input coin_t c, input vst_t hold,
                                   input vst_t s5, input vst_t s10, input vst_t s25);
    case (c)
      COIN_5:  return s5;
      COIN_10: return s10;
      COIN_25: return s25;
      default: return hold;
    endcase
  endfunction

  // Credit addition expressed purely as a state table
  function automatic vst_t credit_after(input vst_t s, input coin_t c);
    case (s)
      ST_C00:  return by_coin(c, s, ST_C05, ST_C10, ST_C25);
      ST_C05:  return by_coin(c, s, ST_C10, ST_C15, ST_C30);
      ST_C10:  return by_coin(c, s, ST_C15, ST_C20, ST_C35);
      ST_C15:  return by_coin(c, s, ST_C20, ST_C25, ST_C40);
      ST_C20:  return by_coin(c, s, ST_C25, ST_C30, ST_P45);
      ST_C25:  return by_coin(c, s, ST_C30, ST_C35, ST_P50);
      ST_C30:  return by_coin(c, s, ST_C35, ST_C40, ST_P55);
      ST_C35:  return by_coin(c, s, ST_C40, ST_P45, ST_P60);
      ST_C40:  return by_coin(c, s, ST_P45, ST_P50, ST_P65);
      default: return s;
    endcase
  endfunction

  // Surplus over the price, as the payback state entered on a sale
  function automatic vst_t refund_entry(input vst_t s);
    case (s)
      ST_P50:  return ST_K1;
      ST_P55:  return ST_K2;
      ST_P60:  return ST_K3;
      ST_P65:  return ST_K4;
      default: return ST_C00;
    endcase
  endfunction

  // One nickel paid back per step
  function automatic vst_t payback_next(input vst_t s);
    case (s)
      ST_K4:   return ST_K3;
      ST_K3:   return ST_K2;
      ST_K2:   return ST_K1;
      default: return ST_C00;
    endcase
  endfunction

endpackage

// File: rtl/vend_strobe_pick.sv
module vend_strobe_pick
  import vend_pkg::*;
(
  input  logic  nickel_i,
  input  logic  dime_i,
  input  logic  quarter_i,
  input  logic  soda_i,
  input  logic  diet_i,
  output coin_t coin_o,
  output pick_t pick_o
);

  // Highest-value coin wins a same-cycle collision
  always_comb begin
    if (quarter_i)      coin_o = COIN_25;
    else if (dime_i)    coin_o = COIN_10;
    else if (nickel_i)  coin_o = COIN_5;
    else                coin_o = COIN_NONE;
  end

  // Regular drink has precedence over diet
  always_comb begin
    if (soda_i)         pick_o = PICK_REG;
    else if (diet_i)    pick_o = PICK_DIET;
    else                pick_o = PICK_NONE;
  end

  always_comb begin
    assert (!(quarter_i && coin_o != COIN_25)); // R2
  end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
  import vend_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  coin_t coin_i,
  input  pick_t pick_i,
  output vst_t  state_o,
  output logic  accepting_o,
  output logic  sel_taken_o,
  output logic  change_step_o
);

  vst_t state_q, state_d;
  logic paid_w;

  assign accepting_o   = is_accepting(state_q);
  assign paid_w        = is_paid(state_q);
  assign sel_taken_o   = paid_w && (pick_i != PICK_NONE);
  assign change_step_o = is_payback(state_q);
  assign state_o       = state_q;

  always_comb begin
    state_d = state_q;
    if (accepting_o) begin
      state_d = credit_after(state_q, coin_i);
    end else if (paid_w) begin
      if (pick_i != PICK_NONE) state_d = refund_entry(state_q);
    end else begin
      state_d = payback_next(state_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_C00;
    else     state_q <= state_d;
  end

  AST_COIN_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (paid_w && pick_i == PICK_NONE) |=> $stable(state_q)); // R5

  AST_CREDIT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (accepting_o && coin_i != COIN_NONE) |=> (state_q != $past(state_q))); // R1

  AST_SALE_EXITS: assert property (@(posedge clk) disable iff (rst)
    sel_taken_o |=> (state_q == ST_C00 || is_payback(state_q))); // R9

  AST_PAYBACK_RUN: assert property (@(posedge clk) disable iff (rst)
    change_step_o |=> (is_payback(state_q) || state_q == ST_C00)); // R7

endmodule

// File: rtl/vend_pulse_out.sv
module vend_pulse_out
  import vend_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pick_t pick_i,
  input  logic  sel_taken_i,
  input  logic  change_step_i,
  output logic  give_soda_o,
  output logic  give_diet_o,
  output logic  change_o
);

  logic give_soda_q, give_diet_q, change_q;

  // Full-cycle registered pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      give_soda_q <= 1'b0;
      give_diet_q <= 1'b0;
      change_q    <= 1'b0;
    end else begin
      give_soda_q <= sel_taken_i && (pick_i == PICK_REG);
      give_diet_q <= sel_taken_i && (pick_i == PICK_DIET);
      change_q    <= change_step_i;
    end
  end

  assign give_soda_o = give_soda_q;
  assign give_diet_o = give_diet_q;
  assign change_o    = change_q;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({give_soda_q, give_diet_q, change_q})); // R4

  AST_GIVE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (give_soda_q || give_diet_q) |=> !(give_soda_q || give_diet_q)); // R3

  AST_CHANGE_LEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(change_q) |-> $past(give_soda_q || give_diet_q)); // R4

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nickel,
  input  logic dime,
  input  logic quarter,
  input  logic soda,
  input  logic diet,
  output logic give_soda,
  output logic give_diet,
  output logic change,
  output logic status
);

  coin_t coin_w;
  pick_t pick_w;
  vst_t  state_w;
  logic  accepting_w, sel_taken_w, change_step_w;

  vend_strobe_pick u_pick (
    .nickel_i  (nickel),
    .dime_i    (dime),
    .quarter_i (quarter),
    .soda_i    (soda),
    .diet_i    (diet),
    .coin_o    (coin_w),
    .pick_o    (pick_w)
  );

  vend_credit_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .coin_i        (coin_w),
    .pick_i        (pick_w),
    .state_o       (state_w),
    .accepting_o   (accepting_w),
    .sel_taken_o   (sel_taken_w),
    .change_step_o (change_step_w)
  );

  vend_pulse_out u_out (
    .clk           (clk),
    .rst           (rst),
    .pick_i        (pick_w),
    .sel_taken_i   (sel_taken_w),
    .change_step_i (change_step_w),
    .give_soda_o   (give_soda),
    .give_diet_o   (give_diet),
    .change_o      (change)
  );

  assign status = accepting_w;

  AST_NO_SALE_UNPAID: assert property (@(posedge clk) disable iff (rst)
    (status && (soda || diet)) |=> !(give_soda || give_diet)); // R6

  AST_STATUS_STATE: assert property (@(posedge clk) disable iff (rst)
    status |-> (state_w inside {ST_C00, ST_C05, ST_C10, ST_C15, ST_C20,
                                ST_C25, ST_C30, ST_C35, ST_C40})); // R1

endmodule

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;

  logic clk = 1'b0;
  logic rst, nickel, dime, quarter, soda, diet;
  logic give_soda, give_diet, change, status;

  int checks = 0;
  int errors = 0;

  // Independent model: cents held and nickels still owed
  int   m_credit = 0;
  int   m_pend   = 0;
  logic e_gs = 0, e_gd = 0, e_ch = 0, e_st = 1;

  always #4 clk = ~clk;

  vend_ctrl u_vend_ctrl (
    .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .quarter(quarter),
    .soda(soda), .diet(diet), .give_soda(give_soda), .give_diet(give_diet),
    .change(change), .status(status)
  );

  function automatic int coin_value(input logic q, input logic d, input logic n);
    if (q) return 25;
    if (d) return 10;
    if (n) return 5;
    return 0;
  endfunction

  function automatic string auto_tag();
    if (e_gs || e_gd) return "R3";
    if (e_ch)         return "R4";
    if (!e_st)        return "R5";
    return "R1";
  endfunction

  task automatic model_step(input logic r, q, d, n, s, dt);
    e_gs = 0; e_gd = 0; e_ch = 0;
    if (r) begin
      m_credit = 0; m_pend = 0;
    end else if (m_pend > 0) begin
      e_ch = 1; m_pend--;
    end else if (m_credit >= 45) begin
      if (s || dt) begin
        e_gs = s; e_gd = !s;
        m_pend = (m_credit - 45) / 5;
        m_credit = 0;
      end
    end else begin
      m_credit += coin_value(q, d, n);
    end
    e_st = (m_pend == 0) && (m_credit < 45);
  endtask

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic r, q, d, n, s, dt, input string tag);
    rst = r; quarter = q; dime = d; nickel = n; soda = s; diet = dt;
    model_step(r, q, d, n, s, dt);
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "give_soda", give_soda, e_gs);
    cmp(tag, "give_diet", give_diet, e_gd);
    cmp(tag, "change",    change,    e_ch);
    cmp(tag, "status",    status,    e_st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; nickel = 0; dime = 0; quarter = 0; soda = 0; diet = 0;
    @(negedge clk);
    cyc(1, 0,0,0,0,0, "R8");
    cyc(0, 0,0,0,0,0, "R8");
    // R1: nine nickels reach the price; the last one drops status
    for (int i = 0; i < 9; i++) cyc(0, 0,0,1,0,0, "R1");
    // R5: coins at price ignored
    cyc(0, 1,0,0,0,0, "R5");
    cyc(0, 0,1,1,0,0, "R5");
    // R3/R9: exact-price sale, no change, back to accepting
    cyc(0, 0,0,0,1,0, "R3");
    cyc(0, 0,0,0,0,0, "R9");
    // R6: selections below price ignored, with a coin in the same cycle
    cyc(0, 0,1,0,0,0, "R1");
    cyc(0, 0,1,0,0,1, "R6");
    cyc(0, 0,0,0,1,1, "R6");
    // R2: all coins at once credit only 25 -> 45 total
    cyc(0, 1,1,1,0,0, "R2");
    // R3: both selections -> soda; no change at 45
    cyc(0, 0,0,0,1,1, "R3");
    // 40 + quarter = 65, then diet, with strobes during payback
    cyc(0, 0,1,0,0,0, "R1");
    cyc(0, 1,0,0,0,0, "R1");
    cyc(0, 0,0,1,0,0, "R1");
    cyc(0, 1,0,0,0,0, "R5");
    cyc(0, 0,1,0,0,1, "R3");
    cyc(0, 1,0,0,1,0, "R7");
    cyc(0, 0,1,1,0,1, "R7");
    cyc(0, 0,0,0,1,0, "R7");
    cyc(0, 1,1,0,0,0, "R4");
    cyc(0, 0,0,0,0,0, "R9");
    // R8: reset in the middle of a payback
    cyc(0, 1,0,0,0,0, "R1");
    cyc(0, 1,0,0,0,0, "R1");
    cyc(0, 0,0,0,1,0, "R3");
    cyc(1, 0,0,0,0,0, "R8");
    cyc(0, 0,0,0,0,0, "R8");
    // Random traffic, fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5000; i++) begin
      logic r, q, d, n, s, dt;
      r  = ($urandom_range(299) == 0);
      q  = ($urandom_range(5) == 0);
      d  = ($urandom_range(4) == 0);
      n  = ($urandom_range(3) == 0);
      s  = ($urandom_range(6) == 0);
      dt = ($urandom_range(6) == 0);
      rst = r; quarter = q; dime = d; nickel = n; soda = s; diet = dt;
      model_step(r, q, d, n, s, dt);
      @(posedge clk);
      @(negedge clk);
      cmp(auto_tag(), "give_soda", give_soda, e_gs);
      cmp(auto_tag(), "give_diet", give_diet, e_gd);
      cmp(auto_tag(), "change",    change,    e_ch);
      cmp(auto_tag(), "status",    status,    e_st);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule